// File: doc/BRIEF.md
# Edge-Timed Phase Difference Counter

This block measures how far a measured square wave lags a reference square wave of the same low frequency, typically a 50 Hz mains signal. Both inputs arrive already squared by external zero-crossing comparators. The block synchronises each input and picks out its rising edges. It then counts microsecond ticks from a reference rise to the next measured rise. The count is latched and reported twice: as a binary microsecond value and as five packed BCD digits.

The block also times the full reference period, tick for tick, so that a downstream stage can turn the lag into degrees. This period also drives the handling of the 0°/360° seam. The phase count runs modulo the last measured period. Edges that fall in the same cycle read as zero. A flag marks any reading that lies within a guard band of either end of the scale, where comparator jitter can make the edge order flip.

The result is a measurement stream with no back-pressure. Each completed measurement raises a one-cycle strobe. The consumer must take the outputs then, or read them at any later point while they are held. Real time cannot be stalled, so no ready input exists. A missed measured edge, or a reference that stops arriving, raises an error and leaves the last result untouched.

Top module: `phase_tic_counter`

## Requirements
- R1: Each input passes through a two-flop synchroniser and a rising-edge detector. If the two input rises are d clock cycles apart, the reading is floor(d / CLK_PER_US) microseconds, counted on a tick that restarts at every reference rise.
- R2: A reference rise clears the counters and starts a measurement. The first measured rise after it stops the count and latches it. Any further measured rises before the next reference rise change nothing.
- R3: `phase_bcd` holds the same value as `phase_us` in decimal, one digit per 4-bit nibble. The least significant digit sits in bits 3:0 and digit k sits in bits 4k+3:4k. Each digit stays within 0 to 9.
- R4: `meas_valid` is high for exactly one cycle per completed measurement, in the cycle in which the new outputs first appear. The outputs then hold until the next measurement.
- R5: `period_us` is the tick count between the two most recent reference rises. It reads 0 until two reference rises have been seen since reset or since a saturation error.
- R6: While `period_us` is non-zero, the phase count wraps to 0 on reaching it, so a reported phase is always below the period in force.
- R7: If a reference rise and a measured rise are detected in the same cycle, the result is 0 with a valid strobe, and a new measurement starts.
- R8: `near_wrap` is latched with each result. It is 1 when the result is below GUARD, or when the period exceeds GUARD and the result is at least the period minus GUARD.
- R9: A reference rise that arrives while a measurement is still open raises `meas_err` and leaves `phase_us`, `phase_bcd` and `near_wrap` unchanged. The period is still updated and a new measurement starts.
- R10: If the period count would pass 2^CNT_W−1, `meas_err` rises, `period_us` drops to 0, and all counting stops until the next reference rise.
- R11: `meas_err` clears on the next valid measurement.
- R12: The synchronous active-high `rst` clears the result, the BCD digits, the period, both flags and the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Squared reference signal (asynchronous) |
| meas_in | input | 1 | Squared measured signal (asynchronous) |
| phase_us | output | CNT_W | Latched lag in microseconds, binary |
| phase_bcd | output | 4*NDIG | Latched lag in microseconds, packed BCD |
| period_us | output | CNT_W | Last reference period in microseconds, 0 if unknown |
| near_wrap | output | 1 | Latched result lies in a guard band next to 0° or 360° |
| meas_valid | output | 1 | One-cycle strobe: new result on the outputs |
| meas_err | output | 1 | Missed measured edge or lost reference |

## Verification
The bench drives exact clock distances between the input rises. It aims at tick-boundary rounding first: a design that counts one tick late, or that drops the pending tick, reads one microsecond short. The seam is probed with rises a few cycles apart, rises in the same cycle, readings just under the period, and a longer period that forces the modulo wrap. A design without the wrap would report a phase above the period, and one that mishandles coincident edges would miss a measurement. Extra measured pulses, a missing measured pulse and a reference that stops arriving check three things: that the stop is armed only once, that the error holds the previous result, and that saturation forgets the period instead of reusing a stale one.

// File: rtl/phs_pkg.sv
package phs_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;
endpackage

// File: rtl/phs_edge_in.sv
module phs_edge_in #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], din};
  end

  // rising edge of the synchronised level, one cycle wide
  assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst) rise |=> !rise); // R1
endmodule

// File: rtl/phs_tick.sv
module phs_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  assign tick = en && (pre == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  pre <= '0;
    else if (en)     pre <= tick ? '0 : pre + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst) tick |=> !tick); // R1
endmodule

// File: rtl/phs_bcd_cnt.sv
module phs_bcd_cnt
  import phs_pkg::*;
#(
  parameter int NDIG = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      inc,
  output logic [NDIG*DIGIT_W-1:0]   nxt_o
);
  logic [NDIG*DIGIT_W-1:0] q;
  logic [NDIG-1:0]         cy;

  assign cy[0] = inc;

  generate
    for (genvar k = 0; k < NDIG; k++) begin : g_dig
      logic [DIGIT_W-1:0] d;
      assign d = q[k*DIGIT_W +: DIGIT_W];
      if (k < NDIG - 1) begin : g_carry
        assign cy[k+1] = cy[k] && (d == DIGIT_MAX);
      end
      assign nxt_o[k*DIGIT_W +: DIGIT_W] = clr    ? '0 :
                                           !cy[k] ? d  :
                                           (d == DIGIT_MAX) ? '0 : d + 1'b1;

      AST_BCD_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst) d <= DIGIT_MAX); // R3
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end
endmodule

// File: rtl/phase_tic_counter.sv
module phase_tic_counter
  import phs_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int CNT_W       = 15,
  parameter int GUARD       = 100,
  parameter int NDIG        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ref_in,
  input  logic                    meas_in,
  output logic [CNT_W-1:0]        phase_us,
  output logic [NDIG*DIGIT_W-1:0] phase_bcd,
  output logic [CNT_W-1:0]        period_us,
  output logic                    near_wrap,
  output logic                    meas_valid,
  output logic                    meas_err
);
  localparam int BW = NDIG * DIGIT_W;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] GRD  = CNT_W'(GUARD);

  logic st, sp, tick;
  logic seen_ref, run;
  logic [CNT_W-1:0] cnt_ph, cnt_per, ph_nxt, per_nxt, per_q, res_q;
  logic [BW-1:0]    bcd_nxt, bcd_q;
  logic             ph_wrap, sat, nw_calc, nw_q, vld_q, err_q;

  phs_edge_in #(.SYNC_STAGES(SYNC_STAGES)) u_ref (
    .clk(clk), .rst(rst), .din(ref_in), .rise(st)
  );
  phs_edge_in #(.SYNC_STAGES(SYNC_STAGES)) u_meas (
    .clk(clk), .rst(rst), .din(meas_in), .rise(sp)
  );

  phs_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .clr(st), .en(seen_ref), .tick(tick)
  );

  // phase count runs modulo the last known period
  always_comb begin
    ph_wrap = run && tick && (per_q != '0) && ((cnt_ph + 1'b1) == per_q);
    if (!(run && tick)) ph_nxt = cnt_ph;
    else if (ph_wrap)   ph_nxt = '0;
    else                ph_nxt = cnt_ph + 1'b1;
    per_nxt = tick ? cnt_per + 1'b1 : cnt_per;
    sat     = seen_ref && tick && (cnt_per == CMAX);
    nw_calc = (ph_nxt < GRD) || ((per_q > GRD) && (ph_nxt >= per_q - GRD));
  end

  phs_bcd_cnt #(.NDIG(NDIG)) u_bcd (
    .clk(clk), .rst(rst),
    .clr(st || ph_wrap),
    .inc(run && tick && !ph_wrap),
    .nxt_o(bcd_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || st) begin
      cnt_ph  <= '0;
      cnt_per <= '0;
    end else begin
      cnt_ph <= ph_nxt;
      if (seen_ref) cnt_per <= per_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_ref <= 1'b0;
      run      <= 1'b0;
      per_q    <= '0;
      res_q    <= '0;
      bcd_q    <= '0;
      nw_q     <= 1'b0;
      vld_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (st) begin
        seen_ref <= 1'b1;
        run      <= 1'b1;
        if (seen_ref) per_q <= per_nxt;
        if (sp) begin
          res_q <= '0;
          bcd_q <= '0;
          nw_q  <= (GRD != '0);
          vld_q <= 1'b1;
          err_q <= 1'b0;
        end else if (run) begin
          err_q <= 1'b1;
        end
      end else if (sat) begin
        err_q    <= 1'b1;
        run      <= 1'b0;
        seen_ref <= 1'b0;
        per_q    <= '0;
      end else if (sp && run) begin
        run   <= 1'b0;
        res_q <= ph_nxt;
        bcd_q <= bcd_nxt;
        nw_q  <= nw_calc;
        vld_q <= 1'b1;
        err_q <= 1'b0;
      end
    end
  end

  assign phase_us   = res_q;
  assign phase_bcd  = bcd_q;
  assign period_us  = per_q;
  assign near_wrap  = nw_q;
  assign meas_valid = vld_q;
  assign meas_err   = err_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) vld_q |=> !vld_q); // R4
  AST_PHASE_BELOW_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (vld_q && per_q != '0) |-> (res_q < per_q)); // R6
  AST_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> ($stable(res_q) && $stable(bcd_q) && !vld_q)); // R9
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst) vld_q |-> !err_q); // R11
  AST_ZERO_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (vld_q && res_q == '0 && GRD != '0) |-> nw_q); // R8
  AST_SAT_FORGETS: assert property (@(posedge clk) disable iff (rst)
    $fell(seen_ref) |-> (err_q && per_q == '0)); // R10
endmodule

// File: tb/tb_phase_tic_counter.sv
`timescale 1ns/1ps
module tb_phase_tic_counter;
  localparam int K = 4;
  localparam int W = 10;
  localparam int G = 8;
  localparam int ND = 5;
  localparam int NV = 10;
  // reference period in clocks, measured-edge offset in clocks
  localparam int VP [NV] = '{400, 400, 400, 400, 400, 600, 600, 320, 320, 320};
  localparam int VD [NV] = '{ 82, 162,   2,   0, 390, 402, 446, 122, 250, 302};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic meas_in = 1'b0;
  logic [W-1:0]    phase_us, period_us;
  logic [4*ND-1:0] phase_bcd;
  logic near_wrap, meas_valid, meas_err;

  int ntests = 0;
  int nfail = 0;
  int nvalid = 0;
  int nerr = 0;
  int err_res = 0;
  logic err_prev = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  phase_tic_counter #(.CLK_PER_US(K), .CNT_W(W), .GUARD(G), .NDIG(ND)) dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .meas_in(meas_in),
    .phase_us(phase_us), .phase_bcd(phase_bcd), .period_us(period_us),
    .near_wrap(near_wrap), .meas_valid(meas_valid), .meas_err(meas_err)
  );

  always @(negedge clk) begin
    if (rst) begin
      err_prev <= 1'b0;
    end else begin
      if (meas_valid) nvalid <= nvalid + 1;
      if (meas_err && !err_prev) begin
        nerr    <= nerr + 1;
        err_res <= int'(phase_us);
      end
      err_prev <= meas_err;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int to_bcd(input int v);
    int r = 0;
    int x = v;
    for (int k = 0; k < ND; k++) begin
      r = r | ((x % 10) << (4 * k));
      x = x / 10;
    end
    return r;
  endfunction

  task automatic run_cycle(input int per_clk, input int d, input int d2);
    for (int i = 0; i < per_clk; i++) begin
      @(negedge clk);
      ref_in  = (i < 20);
      meas_in = (d >= 0 && i >= d && i < d + 10) || (d2 >= 0 && i >= d2 && i < d2 + 10);
    end
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R4: watchdog expired, actual 0 expected 1 completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    int prev_n = 0;
    int v0, e0, r;
    bit nw;
    wait_clks(5);
    rst = 1'b0;
    wait_clks(5);
    // R12 reset state
    chk("R12", int'(phase_us), 0);
    chk("R12", int'(phase_bcd), 0);
    chk("R12", int'(period_us), 0);
    chk("R12", int'({near_wrap, meas_valid, meas_err}), 0);

    for (int v = 0; v < NV; v++) begin
      v0 = nvalid;
      run_cycle(VP[v], VD[v], -1);
      r = (VD[v] == 0) ? 0 : VD[v] / K;
      if (prev_n != 0) r = r % prev_n;
      nw = (r < G) || (prev_n > G && r >= prev_n - G);
      chk("R4", nvalid - v0, 1);
      if (VD[v] == 0)                         chk("R7", int'(phase_us), r);
      else if (prev_n != 0 && VD[v] / K >= prev_n) chk("R6", int'(phase_us), r);
      else                                    chk("R1", int'(phase_us), r);
      chk("R3", int'(phase_bcd), to_bcd(r));
      chk("R5", int'(period_us), prev_n);
      chk("R8", int'(near_wrap), int'(nw));
      chk("R11", int'(meas_err), 0);
      prev_n = VP[v] / K;
    end

    // R2: second measured pulse in the same period is ignored
    v0 = nvalid;
    run_cycle(400, 100, 200);
    chk("R2", nvalid - v0, 1);
    chk("R2", int'(phase_us), 25);
    chk("R5", int'(period_us), 80);

    // R9: missing measured edge, then a normal period
    v0 = nvalid; e0 = nerr;
    run_cycle(400, -1, -1);
    chk("R9", nvalid - v0, 0);
    run_cycle(400, 202, -1);
    chk("R9", nerr - e0, 1);
    chk("R9", err_res, 25);
    chk("R9", int'(period_us), 100);
    chk("R11", int'(meas_err), 0);
    chk("R1", int'(phase_us), 50);

    // R10: reference stops, period counter saturates
    e0 = nerr;
    run_cycle(4200, 50, -1);
    chk("R10", int'(meas_err), 1);
    chk("R10", int'(period_us), 0);
    chk("R10", int'(phase_us), 12);
    chk("R10", nerr - e0, 1);
    run_cycle(400, 362, -1);
    chk("R10", int'(period_us), 0);
    chk("R10", int'(phase_us), 90);
    chk("R11", int'(meas_err), 0);
    chk("R3", int'(phase_bcd), to_bcd(90));

    // R12: reset after activity
    @(negedge clk); rst = 1'b1;
    wait_clks(3);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R12", int'(phase_us), 0);
    chk("R12", int'(phase_bcd), 0);
    chk("R12", int'(period_us), 0);
    chk("R12", int'({near_wrap, meas_valid, meas_err}), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule